// File: doc/BRIEF.md
# Recirculating Bit-Serial Loop Memory

This block stores a fixed number of bits (512 by default) in a closed serial loop instead of an addressed array. The bits circulate continuously, and only the bit at the head of the loop can be read or replaced on any shift step. Each step is driven by two alternating, non-overlapping shift phases produced inside the block. On each step the bit that leaves the head either re-enters the tail unchanged or is replaced by a new write bit.

A position counter follows the bit index that is currently at the head. A requester holds a request with a bit address. It is stalled until the counter reaches that address. At that point the block raises `ready` for a single clock cycle. During that cycle the head bit is presented on `rd_bit`, and a write bit, if one is requested, is taken in place of the exiting bit. A wait can last up to one full rotation of the loop.

Two select inputs, intended for a row line and a column line of a device grid, must both be high for the device to answer a request.

Top module: `circ_shift_mem`

## Requirements
- R1: The loop holds DEPTH bits (default 512), addressed 0 to DEPTH-1. A read of an address returns the value most recently written to it.
- R2: On a step that carries no write, the bit leaving the head re-enters the tail, so stored data survives any number of rotations.
- R3: `shift_ph1` and `shift_ph2` are never high together. Each is high for one cycle, with GAP idle cycles (default 1) after each. A full step therefore takes 2*(GAP+1) = 4 cycles, and `shift_ph1` is high in the first cycle after reset.
- R4: `bit_pos` is 0 after reset. It advances by one on each cycle in which `shift_ph2` is high, wraps from DEPTH-1 to 0, and does not change otherwise.
- R5: The device is selected only when `sel_row` and `sel_col` are both 1. While it is deselected, `rd_bit` is 0, `ready` stays 0, and no write is taken.
- R6: `ready` is high for exactly one clock cycle per rotation, in a `shift_ph1` cycle in which the device is selected, `req_valid` is 1 and `bit_pos` equals `req_addr`. In that cycle `rd_bit` shows the bit stored at `req_addr`.
- R7: When `req_write` is 1 in a `ready` cycle, `wr_bit` replaces the bit at `req_addr` on that step.
- R8: A request that is held with the device selected receives `ready` within DEPTH steps (DEPTH*4 cycles) of being raised.
- R9: Reset clears every stored bit to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_row | input | 1 | Row select line |
| sel_col | input | 1 | Column select line |
| req_valid | input | 1 | An access request is pending |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 9 | Requested bit address |
| wr_bit | input | 1 | Bit to store on a write |
| rd_bit | output | 1 | Head bit while selected, 0 otherwise |
| ready | output | 1 | One-cycle pulse when the requested bit is at the head |
| shift_ph1 | output | 1 | First shift phase: the entry bit is captured |
| shift_ph2 | output | 1 | Second shift phase: the loop advances |
| bit_pos | output | 9 | Index of the bit currently at the head |

## Verification
The assertions assume that a requester keeps `req_valid`, `req_addr`, `req_write` and `wr_bit` stable until it sees `ready`, and then drops `req_valid` before the next step comes round. The bench drives each request at a falling edge and holds it until it samples the pulse. It then releases the request at the next falling edge, well inside the three idle cycles that follow the pulse. Random accesses use addresses drawn across the whole loop, with a reference array as the expected contents. Directed cases cover both ends of the address range, an address that has just passed the head (the longest wait), and a long deselected interval.

// File: rtl/circ_shift_mem.sv
module circ_shift_mem #(
  parameter int DEPTH = 512,
  parameter int GAP   = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sel_row,
  input  logic                     sel_col,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [$clog2(DEPTH)-1:0] req_addr,
  input  logic                     wr_bit,
  output logic                     rd_bit,
  output logic                     ready,
  output logic                     shift_ph1,
  output logic                     shift_ph2,
  output logic [$clog2(DEPTH)-1:0] bit_pos
);
  localparam int AW  = $clog2(DEPTH);
  localparam int PER = 2 * (GAP + 1);
  localparam int PW  = $clog2(PER);
  localparam logic [AW-1:0] LAST_POS = AW'(DEPTH - 1);
  localparam logic [PW-1:0] PH2_AT   = PW'(GAP + 1);
  localparam logic [PW-1:0] PH_END   = PW'(PER - 1);

  logic [PW-1:0]    ph_cnt;
  logic [DEPTH-1:0] loop_q;
  logic             stage_q;
  logic             selected;
  logic             head;
  logic             entry;

  assign selected  = sel_row & sel_col;
  assign head      = loop_q[DEPTH-1];
  assign shift_ph1 = (ph_cnt == '0);
  assign shift_ph2 = (ph_cnt == PH2_AT);
  assign ready     = shift_ph1 & selected & req_valid & (bit_pos == req_addr);
  assign rd_bit    = selected & head;
  assign entry     = (ready & req_write) ? wr_bit : head;

  always_ff @(posedge clk) begin
    if (!rst_n) ph_cnt <= '0;
    else if (ph_cnt == PH_END) ph_cnt <= '0;
    else ph_cnt <= ph_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loop_q  <= '0;
      stage_q <= 1'b0;
      bit_pos <= '0;
    end else begin
      if (shift_ph1) stage_q <= entry;
      if (shift_ph2) begin
        loop_q  <= {loop_q[DEPTH-2:0], stage_q};
        bit_pos <= (bit_pos == LAST_POS) ? '0 : bit_pos + 1'b1;
      end
    end
  end

  AST_PHASE_GAP: assert property (@(posedge clk) disable iff (!rst_n) shift_ph2 |-> !$past(shift_ph1)); // R3
  AST_PH1_SPACING: assert property (@(posedge clk) disable iff (!rst_n) shift_ph1 |=> !shift_ph1); // R3
  AST_POS_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (shift_ph2 && bit_pos == LAST_POS) |=> bit_pos == '0); // R4
  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !shift_ph2 |=> $stable(bit_pos)); // R4
  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !(sel_row && sel_col) |-> (!rd_bit && !ready)); // R5
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n) ready |=> !ready); // R6
  AST_RECIRC: assert property (@(posedge clk) disable iff (!rst_n) (shift_ph1 && !(ready && req_write)) |=> stage_q == $past(head)); // R2
  AST_WRITE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (ready && req_write) |=> stage_q == $past(wr_bit)); // R7
endmodule

// File: tb/circ_shift_mem_bench.sv
module circ_shift_mem_bench;
  localparam int DEPTH = 512;
  localparam int AW = 9;
  localparam int PER = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_row = 1'b1, sel_col = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, wr_bit = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic rd_bit, ready, shift_ph1, shift_ph2;
  logic [AW-1:0] bit_pos;

  int checks = 0;
  int failures = 0;
  bit ref_mem [DEPTH];
  bit done = 0;

  always #5 clk = ~clk;

  circ_shift_mem #(.DEPTH(DEPTH), .GAP(1)) u_circ_shift_mem (
    .clk(clk), .rst_n(rst_n), .sel_row(sel_row), .sel_col(sel_col),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .wr_bit(wr_bit), .rd_bit(rd_bit), .ready(ready),
    .shift_ph1(shift_ph1), .shift_ph2(shift_ph2), .bit_pos(bit_pos)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] next_pos(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // phase and position monitor (R3, R4)
  int since_ph1 = 0;
  logic [AW-1:0] prev_pos = '0;
  bit mon_on = 0;
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      if (shift_ph1 && shift_ph2) check(0, "R3 overlap", 1, 0);
      if (shift_ph2 && since_ph1 != 2) check(0, "R3 gap", since_ph1, 2);
      if (shift_ph1 && since_ph1 != PER) check(0, "R3 period", since_ph1, PER);
      if (bit_pos != prev_pos) begin
        if (bit_pos != next_pos(prev_pos)) check(0, "R4 step", bit_pos, next_pos(prev_pos));
        if (prev_pos == AW'(DEPTH - 1)) check(bit_pos == 0, "R4 wrap", bit_pos, 0);
      end
    end
    if (shift_ph1) since_ph1 = 1; else since_ph1++;
    prev_pos = bit_pos;
    if (rst_n) mon_on = 1;
  end

  task automatic access(input int addr, input bit wr, input bit val, input string tag);
    int waited = 0;
    bit got;
    req_addr = AW'(addr); req_write = wr; wr_bit = val; req_valid = 1'b1;
    #1;
    while (!ready && waited <= DEPTH * PER + PER) begin
      @(negedge clk); #1; waited++;
    end
    check(waited <= DEPTH * PER, {tag, " R8 wait"}, waited, DEPTH * PER);
    got = rd_bit;
    check(bit_pos == AW'(addr), {tag, " R6 pos at ready"}, bit_pos, addr);
    if (!wr) check(got == ref_mem[addr], {tag, " R1 read"}, got, ref_mem[addr]);
    else ref_mem[addr] = val;
    @(posedge clk); #1;
    check(!ready, {tag, " R6 single pulse"}, ready, 0);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (50) @(posedge clk);
    if (!done) begin
      #100000000;
    end
  end

  initial begin
    #3000000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd19));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(bit_pos == 0, "R4 reset pos", bit_pos, 0);
    check(shift_ph1 == 1, "R3 ph1 first", shift_ph1, 1);
    check(rd_bit == 0, "R9 reset head", rd_bit, 0);
    @(negedge clk);

    // R9: unwritten addresses read 0
    access(300, 0, 0, "R9 cleared");
    // boundaries R7
    access(511, 1, 1, "R7 top");
    access(0, 1, 1, "R7 bottom");
    access(511, 0, 0, "R1 top back");
    access(0, 0, 0, "R1 bottom back");
    // R8 worst case: request the address that just passed the head
    @(negedge clk);
    while (!shift_ph1) @(negedge clk);
    access((int'(bit_pos) + DEPTH - 1) % DEPTH, 1, 1, "R8 longest");

    // R5 deselected: no ready, rd_bit 0, write not taken
    begin
      int bad_ready = 0, bad_bit = 0;
      sel_col = 1'b0;
      req_addr = 9'd100; req_write = 1'b1; wr_bit = 1'b1; req_valid = 1'b1;
      for (int i = 0; i < DEPTH * PER + 8; i++) begin
        @(negedge clk);
        if (ready) bad_ready++;
        if (rd_bit) bad_bit++;
      end
      req_valid = 1'b0;
      check(bad_ready == 0, "R5 no ready", bad_ready, 0);
      check(bad_bit == 0, "R5 quiet output", bad_bit, 0);
      sel_col = 1'b1; sel_row = 1'b0;
      @(negedge clk);
      check(rd_bit == 0 && ready == 0, "R5 row off", rd_bit, 0);
      sel_row = 1'b1;
      @(negedge clk);
      access(100, 0, 0, "R5 write ignored");
    end

    // random mix, R1 R2 R7
    for (int n = 0; n < 30; n++) begin
      int a = $urandom_range(DEPTH - 1);
      bit w = ($urandom_range(1) == 1);
      access(a, w, 1'($urandom_range(1)), w ? "R7 rnd write" : "R2 rnd read");
    end
    access(511, 0, 0, "R2 top retained");
    access(0, 0, 0, "R2 bottom retained");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule